// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Timing Generator

This block is a four-stage twisted-ring (switch-tail) counter. It steps through eight states and turns each state into its own timing strobe. The four stages are called A, B, C and E, with A first in the chain. The complement of the last stage E feeds back into A. Each strobe is a single two-input AND of stage outputs, so a strobe decode has the depth of one gate.

A plain twisted ring that starts in one of its eight unused patterns stays among unused patterns forever. Here the input of stage C is gated so that every unused pattern drains back into the legal cycle within a few enabled clocks. The block has a clock enable, and while the enable is low the ring holds its state.

The reset is asynchronous and active-low. Its release is synchronised to the clock by a two-flop chain. The pattern loaded at reset is a parameter whose default is all zeros.

Top module: `jc_timing_gen`

## Requirements
- R1: While rst_n is low, state equals RESET_STATE (default 4'b0000) without waiting for a clock edge. After rst_n rises, the state ignores en for the first two rising edges. The first edge that can advance the state is the third.
- R2: When en is low at a rising edge, state keeps its value across that edge.
- R3: The state bits are state[3]=A, state[2]=B, state[1]=C and state[0]=E. On each enabled edge the stages load as follows: A gets the complement of E, B gets A, C gets (A OR C) AND B, and E gets C.
- R4: Starting from 4'b0000, successive enabled edges give 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001, and then 0000 again.
- R5: In each of the eight cycle states, exactly one strobe bit is high. It is strobe[k], where k is the position of the state in the R4 list (0000 gives bit 0, 0001 gives bit 7). The strobes therefore advance one bit upward per enabled edge.
- R6: Each strobe bit is a two-input AND of stage outputs, and this holds in every state, including unused ones:
  - strobe[0] = ~A&~E, strobe[1] = A&~B, strobe[2] = B&~C, strobe[3] = C&~E
  - strobe[4] = A&E, strobe[5] = ~A&B, strobe[6] = ~B&C, strobe[7] = ~C&E
- R7: From any of the eight patterns outside the R4 list, the state enters the R4 cycle within at most 5 enabled edges and then stays in it.
- R8: RESET_STATE may be set to any 4-bit pattern, including an unused one. After reset, the counter proceeds from that pattern according to R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Clock enable; low holds the state |
| state | output | 4 | Stage outputs {A,B,C,E} |
| strobe | output | 8 | Decoded timing strobes, one per cycle state |

## Verification
The assertions assume that en is a synchronous level, stable around the rising edge. They also assume that the stage register changes only through clocked updates or the reset. In particular, nothing is expected to write the stage register from outside the block.

The bench follows both assumptions. It changes en only on falling edges, and it never forces the stage register. To reach the unused patterns, it builds extra instances whose reset pattern is each unused code in turn. Every recovery path therefore starts from a legal reset and not from an injected upset.

// File: rtl/jc_pkg.sv
package jc_pkg;

  localparam int JC_STAGES  = 4;
  localparam int JC_STROBES = 2 * JC_STAGES;

  typedef logic [JC_STAGES-1:0]  jc_state_t;
  typedef logic [JC_STROBES-1:0] jc_strobe_t;

  // True when s is one of the 2*JC_STAGES patterns of the twisted-ring cycle:
  // a run of ones filled from the top or a run of ones filled from the bottom.
  function automatic logic jc_in_cycle(jc_state_t s);
    logic       hit;
    jc_state_t  ones;
    hit  = 1'b0;
    ones = '1;
    for (int k = 0; k <= JC_STAGES; k++) begin
      if (s == (ones >> k) || s == ~(ones >> k)) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/jc_rst_sync.sv
module jc_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [SYNC_STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/jc_shift_core.sv
module jc_shift_core
  import jc_pkg::*;
#(
  parameter jc_state_t RESET_STATE   = '0,
  parameter int        RECOVER_LIMIT = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  output jc_state_t state
);

  localparam int IA = JC_STAGES - 1;
  localparam int IB = JC_STAGES - 2;
  localparam int IC = JC_STAGES - 3;
  localparam int IE = 0;
  localparam int RUN_W = $clog2(RECOVER_LIMIT + 2) + 1;

  jc_state_t state_q, state_d;

  // next-state: shift with twisted feedback and a repair term on stage C
  always_comb begin
    state_d     = state_q;
    state_d[IA] = ~state_q[IE];
    state_d[IB] = state_q[IA];
    state_d[IC] = (state_q[IA] | state_q[IC]) & state_q[IB];
    state_d[IE] = state_q[IC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= RESET_STATE;
    else if (en) state_q <= state_d;
  end

  assign state = state_q;

  // checker state: enabled edges spent outside the cycle
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_q <= '0;
    else if (jc_in_cycle(state_q)) run_q <= '0;
    else if (en && run_q != '1)   run_q <= run_q + RUN_W'(1);
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(state_q));

  // R4
  stay_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && jc_in_cycle(state_q)) |=> jc_in_cycle(state_q));

  // R7
  recovery_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(RECOVER_LIMIT));

endmodule

// File: rtl/jc_decode.sv
module jc_decode
  import jc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  jc_state_t  state,
  output jc_strobe_t strobe
);

  // s[j] is stage j counted from the head of the chain
  logic [JC_STAGES-1:0] s;

  genvar j;
  generate
    for (j = 0; j < JC_STAGES; j++) begin : g_order
      assign s[j] = state[JC_STAGES-1-j];
    end
  endgenerate

  assign strobe[0]         = ~s[0] & ~s[JC_STAGES-1];
  assign strobe[JC_STAGES] =  s[0] &  s[JC_STAGES-1];

  genvar k;
  generate
    for (k = 1; k < JC_STAGES; k++) begin : g_edge
      // filling phase: first 1-to-0 step
      assign strobe[k]             =  s[k-1] & ~s[k];
      // draining phase: first 0-to-1 step
      assign strobe[JC_STAGES + k] = ~s[k-1] &  s[k];
    end
  endgenerate

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jc_in_cycle(state) |-> $onehot(strobe));

endmodule

// File: rtl/jc_timing_gen.sv
module jc_timing_gen
  import jc_pkg::*;
#(
  parameter jc_state_t RESET_STATE   = '0,
  parameter int        RECOVER_LIMIT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  output logic [3:0] state,
  output logic [7:0] strobe
);

  logic       rst_n_sync;
  jc_state_t  ring;
  jc_strobe_t strb;

  jc_rst_sync #(.SYNC_STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  jc_shift_core #(
    .RESET_STATE   (RESET_STATE),
    .RECOVER_LIMIT (RECOVER_LIMIT)
  ) u_core (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .en    (en),
    .state (ring)
  );

  jc_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .state  (ring),
    .strobe (strb)
  );

  assign state  = ring;
  assign strobe = strb;

  // R5
  strobe_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (en && jc_in_cycle(ring)) |=> strb == {$past(strb[6:0]), $past(strb[7])});

endmodule

// File: tb/jc_timing_gen_test.sv
module jc_timing_gen_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0] state;
  logic [7:0] strobe;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // k-th pattern of the legal cycle (R4), built from run lengths of ones
  function automatic logic [3:0] cyc_pat(int k);
    if (k <= 4) return ~(4'hF >> k);
    return 4'hF >> (k - 4);
  endfunction

  function automatic int cyc_pos(logic [3:0] v);
    for (int k = 0; k < 8; k++) if (cyc_pat(k) == v) return k;
    return -1;
  endfunction

  function automatic logic [3:0] unused_pat(int n);
    int c = 0;
    for (int v = 0; v < 16; v++) begin
      if (cyc_pos(4'(v)) < 0) begin
        if (c == n) return 4'(v);
        c++;
      end
    end
    return 4'h0;
  endfunction

  // R3 equations, state = {A,B,C,E}
  function automatic logic [3:0] nxt(logic [3:0] v);
    return {~v[0], v[3], (v[3] | v[1]) & v[2], v[1]};
  endfunction

  // R6 terms
  function automatic logic [7:0] dec(logic [3:0] v);
    logic a, b, c, e;
    {a, b, c, e} = v;
    return {~c & e, ~b & c, ~a & b, a & e, c & ~e, b & ~c, a & ~b, ~a & ~e};
  endfunction

  jc_timing_gen uut (.clk(clk), .rst_n(rst_n), .en(en), .state(state), .strobe(strobe));

  logic [3:0] rec_state [8];
  logic [7:0] rec_strobe [8];

  genvar g;
  generate
    for (g = 0; g < 8; g++) begin : g_rec
      jc_timing_gen #(.RESET_STATE(unused_pat(g))) u_rec (
        .clk(clk), .rst_n(rst_n), .en(en),
        .state(rec_state[g]), .strobe(rec_strobe[g]));
    end
  endgenerate

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  logic [3:0] exp_s;
  logic [3:0] exp_r [8];
  int rec_first [8];

  task automatic step(bit e_val, bit live, int n);
    logic [3:0] prev;
    prev = state;
    en = e_val;
    @(posedge clk);
    @(negedge clk);
    if (live && e_val) begin
      exp_s = nxt(exp_s);
      for (int i = 0; i < 8; i++) exp_r[i] = nxt(exp_r[i]);
    end
    if (!live) chk(state == prev, "R1 hold after release", {4'h0, state}, {4'h0, prev});
    else if (!e_val) chk(state == prev, "R2 hold en low", {4'h0, state}, {4'h0, prev});
    chk(state == exp_s, "R3 next state", {4'h0, state}, {4'h0, exp_s});
    if (live && e_val)
      chk(cyc_pos(state) == ((cyc_pos(prev) + 1) % 8), "R4 cycle order",
          {4'h0, state}, {4'h0, cyc_pat((cyc_pos(prev) + 1) % 8)});
    chk(strobe == (8'h1 << cyc_pos(exp_s)), "R5 one-hot strobe", strobe, 8'h1 << cyc_pos(exp_s));
    for (int i = 0; i < 8; i++) begin
      chk(rec_state[i] == exp_r[i], "R8 parameter reset trajectory",
          {4'h0, rec_state[i]}, {4'h0, exp_r[i]});
      chk(rec_strobe[i] == dec(rec_state[i]), "R6 strobe terms", rec_strobe[i], dec(rec_state[i]));
      if (rec_first[i] < 0 && cyc_pos(rec_state[i]) >= 0) rec_first[i] = n;
      if (rec_first[i] >= 0)
        chk(cyc_pos(rec_state[i]) >= 0, "R7 stays in cycle", {4'h0, rec_state[i]}, 8'h0);
    end
  endtask

  initial begin
    int n;
    for (int i = 0; i < 8; i++) rec_first[i] = -1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk(state == 4'b0000, "R1 reset state", {4'h0, state}, 8'h00);
    chk(strobe == 8'h01, "R1 reset strobe", strobe, 8'h01);
    for (int i = 0; i < 8; i++) begin
      exp_r[i] = unused_pat(i);
      chk(rec_state[i] == exp_r[i], "R8 reset pattern", {4'h0, rec_state[i]}, {4'h0, exp_r[i]});
    end
    exp_s = 4'b0000;
    rst_n = 1'b1;
    step(1'b1, 1'b0, 0);
    step(1'b1, 1'b0, 0);
    n = 0;
    for (int t = 0; t < 70; t++) begin
      bit e_val;
      e_val = (t < 8) ? 1'b1 : ((t % 5) != 3 && (t % 7) != 6);
      if (e_val) n++;
      step(e_val, 1'b1, n);
    end
    for (int i = 0; i < 8; i++)
      chk(rec_first[i] >= 0 && rec_first[i] <= 5, "R7 recovery bound",
          8'(rec_first[i]), 8'd5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule